// File: doc/BRIEF.md
# Exception Entry Register Controller

This block performs the register side of taking a synchronous exception or a debug exception in a processor core. When a request arrives, the block classifies the entry from the current status word, records the faulting program counter, the cause code and, if asked, the faulting virtual address in the matching save registers, and computes the status word the handler will run with. In the cycle after the request, it presents a one-cycle vector select that tells the fetch logic which handler to start.

A general request records its cause in the exception cause register and sets the exception-mode bit of the status word. If that bit was already set, the entry counts as a double exception. A debug request uses its own save registers at the configured debug level and raises the interrupt level of the status word to that level. It is accepted only while the current interrupt level is strictly below the debug level. Fetch, pipeline flush and interrupt arbitration belong to the surrounding core. One parameter sets the debug level. A second parameter says whether a separate double-exception PC register exists.

The controller is a state machine whose state names the entry taken on the last edge. `ST_IDLE` means no entry. `ST_KERNEL`, `ST_USER`, `ST_DOUBLE` and `ST_DEBUG` each mean one entry of that kind. Every state moves on each edge to the state the arbiter picks from the current request: `ST_DEBUG` on an accepted debug request, `ST_DOUBLE`/`ST_USER`/`ST_KERNEL` on a general request, otherwise `ST_IDLE`. Any state can therefore follow any other. The vector select is decoded from the state alone.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, every save register, the exception cause register, the debug cause register and `ps_out` read zero, and `vec_valid` is low.
- R2: A general request with status bit 4 (exception mode) clear writes `fault_pc` into `epc1` on the next clock edge. During the following cycle, `vec_sel` is 1 (user) when status bit 5 is set and 0 (kernel) when it is clear.
- R3: Every accepted general request loads `exc_cause` with `gen_cause`. It also loads `ps_out` with `ps_in` with bit 4 forced to 1 and all other bits unchanged.
- R4: A general request with status bit 4 already set gives `vec_sel` 2 (double). With `HAS_DEPC`=1 the PC goes to `depc` and `epc1` keeps its value. With `HAS_DEPC`=0 the PC goes to `epc1` and `depc` reads zero.
- R5: `exc_vaddr` loads `fault_vaddr` only on an accepted general request with `gen_vaddr_valid` high. Otherwise it keeps its value.
- R6: A debug request is accepted only when `ps_in[3:0]` is strictly less than `DBG_LEVEL`. A rejected debug request alone changes no register and produces no vector pulse.
- R7: An accepted debug request loads `dbg_cause_q` with `dbg_cause`, `epc_dbg` with `fault_pc` and `eps_dbg` with `ps_in`. It loads `ps_out` with `ps_in` with bits [3:0] replaced by `DBG_LEVEL` and bit 4 set. The vector select is 3 (debug).
- R8: When an accepted debug request and a general request arrive in the same cycle, only the debug entry happens: `epc1`, `depc`, `exc_cause` and `exc_vaddr` keep their values. When the debug request is rejected, the general request proceeds as if alone.
- R9: `vec_valid` is high for exactly the cycle after each accepted request and low after a cycle with no accepted request. Back-to-back requests give back-to-back pulses, each with its own vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_req | input | 1 | General exception request, one cycle per request |
| gen_cause | input | CAUSE_W | Cause code for a general exception |
| gen_vaddr_valid | input | 1 | The general request carries a faulting address |
| fault_vaddr | input | XLEN | Faulting virtual address |
| dbg_req | input | 1 | Debug exception request |
| dbg_cause | input | DCAUSE_W | Cause bits for a debug exception |
| fault_pc | input | XLEN | PC of the excepting instruction |
| ps_in | input | XLEN | Current processor status word |
| epc1 | output | XLEN | Level-1 exception PC |
| depc | output | XLEN | Double-exception PC (zero when absent) |
| exc_cause | output | CAUSE_W | Exception cause register |
| exc_vaddr | output | XLEN | Exception virtual address register |
| dbg_cause_q | output | DCAUSE_W | Debug cause register |
| epc_dbg | output | XLEN | Exception PC at the debug level |
| eps_dbg | output | XLEN | Saved status word at the debug level |
| ps_out | output | XLEN | Status word for the handler |
| vec_valid | output | 1 | Vector select is valid this cycle |
| vec_sel | output | 2 | 0 kernel, 1 user, 2 double, 3 debug |

## Verification
A general request and a debug request can land in the same cycle. The bench raises both together with the status interrupt level below `DBG_LEVEL`. It then expects a debug vector, new debug registers, and unchanged cause, address and PC registers on the general side. It repeats the collision with the interrupt level at or above `DBG_LEVEL`. There it expects the general entry exactly as it would be alone and an unchanged debug cause.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    // Status word field positions
    localparam int PS_IL_LSB   = 0;
    localparam int PS_IL_W     = 4;
    localparam int PS_EXCM_BIT = 4;
    localparam int PS_UM_BIT   = 5;

    typedef enum logic [1:0] {
        VEC_KERNEL = 2'd0,
        VEC_USER   = 2'd1,
        VEC_DOUBLE = 2'd2,
        VEC_DEBUG  = 2'd3
    } vec_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_KERNEL = 3'd1,
        ST_USER   = 3'd2,
        ST_DOUBLE = 3'd3,
        ST_DEBUG  = 3'd4
    } entry_st_e;

endpackage

// File: rtl/exc_entry_arbiter.sv
module exc_entry_arbiter
    import exc_entry_pkg::*;
#(
    parameter int DBG_LEVEL = 6
) (
    input  logic                 gen_req,
    input  logic                 dbg_req,
    input  logic [PS_IL_W-1:0]   ps_il,
    input  logic                 ps_excm,
    input  logic                 ps_um,
    output entry_st_e            nxt_state,
    output logic                 gen_take,
    output logic                 dbl_take,
    output logic                 dbg_take
);
    localparam logic [PS_IL_W-1:0] DBG_IL = PS_IL_W'(DBG_LEVEL);

    logic dbg_ok;

    always_comb begin
        dbg_ok    = dbg_req && (ps_il < DBG_IL);
        nxt_state = ST_IDLE;
        if (dbg_ok) begin
            nxt_state = ST_DEBUG;
        end else if (gen_req) begin
            if (ps_excm)    nxt_state = ST_DOUBLE;
            else if (ps_um) nxt_state = ST_USER;
            else            nxt_state = ST_KERNEL;
        end
        dbg_take = dbg_ok;
        gen_take = gen_req && !dbg_ok;
        dbl_take = gen_take && ps_excm;
    end

    // A debug request at or above the debug level is never taken (R6)
    always_comb begin
        if (dbg_req && (ps_il >= DBG_IL)) begin
            assert_dbg_gate_R6: assert (!dbg_take && nxt_state != ST_DEBUG);
        end
    end
endmodule

// File: rtl/exc_entry_gen_regs.sv
module exc_entry_gen_regs #(
    parameter int XLEN     = 32,
    parameter int CAUSE_W  = 6,
    parameter bit HAS_DEPC = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gen_take,
    input  logic               dbl_take,
    input  logic               vaddr_wr,
    input  logic [XLEN-1:0]    pc,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    vaddr,
    output logic [XLEN-1:0]    epc1,
    output logic [XLEN-1:0]    depc,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [XLEN-1:0]    exc_vaddr
);
    logic epc1_wr;
    logic vaddr_en;

    // Without a double-exception PC register, double entries fall back to epc1
    assign epc1_wr  = gen_take && (!dbl_take || !HAS_DEPC);
    assign vaddr_en = gen_take && vaddr_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc1      <= '0;
            exc_cause <= '0;
            exc_vaddr <= '0;
        end else begin
            if (epc1_wr)  epc1      <= pc;
            if (gen_take) exc_cause <= cause;
            if (vaddr_en) exc_vaddr <= vaddr;
        end
    end

    generate
        if (HAS_DEPC) begin : g_depc
            logic [XLEN-1:0] depc_q;
            always_ff @(posedge clk) begin
                if (!rst_n)        depc_q <= '0;
                else if (dbl_take) depc_q <= pc;
            end
            assign depc = depc_q;
        end else begin : g_no_depc
            assign depc = '0;
        end
    endgenerate

    assert_vaddr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(gen_take && vaddr_wr) |=> $stable(exc_vaddr));

    assert_depc_epc1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_take && HAS_DEPC) |=> ($stable(epc1) && depc == $past(pc)));
endmodule

// File: rtl/exc_entry_dbg_regs.sv
module exc_entry_dbg_regs #(
    parameter int XLEN     = 32,
    parameter int DCAUSE_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dbg_take,
    input  logic [XLEN-1:0]     pc,
    input  logic [DCAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]     ps_in,
    output logic [DCAUSE_W-1:0] dbg_cause_q,
    output logic [XLEN-1:0]     epc_dbg,
    output logic [XLEN-1:0]     eps_dbg
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_cause_q <= '0;
            epc_dbg     <= '0;
            eps_dbg     <= '0;
        end else if (dbg_take) begin
            dbg_cause_q <= cause;
            epc_dbg     <= pc;
            eps_dbg     <= ps_in;
        end
    end

    assert_dbg_save_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_take |=> (eps_dbg == $past(ps_in) && epc_dbg == $past(pc)));

    assert_dbg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_take |=> ($stable(dbg_cause_q) && $stable(eps_dbg)));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int CAUSE_W   = 6,
    parameter int DCAUSE_W  = 6,
    parameter int DBG_LEVEL = 6,
    parameter bit HAS_DEPC  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gen_req,
    input  logic [CAUSE_W-1:0]  gen_cause,
    input  logic                gen_vaddr_valid,
    input  logic [XLEN-1:0]     fault_vaddr,
    input  logic                dbg_req,
    input  logic [DCAUSE_W-1:0] dbg_cause,
    input  logic [XLEN-1:0]     fault_pc,
    input  logic [XLEN-1:0]     ps_in,
    output logic [XLEN-1:0]     epc1,
    output logic [XLEN-1:0]     depc,
    output logic [CAUSE_W-1:0]  exc_cause,
    output logic [XLEN-1:0]     exc_vaddr,
    output logic [DCAUSE_W-1:0] dbg_cause_q,
    output logic [XLEN-1:0]     epc_dbg,
    output logic [XLEN-1:0]     eps_dbg,
    output logic [XLEN-1:0]     ps_out,
    output logic                vec_valid,
    output logic [1:0]          vec_sel
);
    localparam logic [PS_IL_W-1:0] DBG_IL = PS_IL_W'(DBG_LEVEL);

    entry_st_e       state_q;
    entry_st_e       nxt_state;
    logic            gen_take;
    logic            dbl_take;
    logic            dbg_take;
    logic [XLEN-1:0] ps_nxt;

    exc_entry_arbiter #(
        .DBG_LEVEL (DBG_LEVEL)
    ) u_arb (
        .gen_req   (gen_req),
        .dbg_req   (dbg_req),
        .ps_il     (ps_in[PS_IL_LSB +: PS_IL_W]),
        .ps_excm   (ps_in[PS_EXCM_BIT]),
        .ps_um     (ps_in[PS_UM_BIT]),
        .nxt_state (nxt_state),
        .gen_take  (gen_take),
        .dbl_take  (dbl_take),
        .dbg_take  (dbg_take)
    );

    exc_entry_gen_regs #(
        .XLEN     (XLEN),
        .CAUSE_W  (CAUSE_W),
        .HAS_DEPC (HAS_DEPC)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_take  (gen_take),
        .dbl_take  (dbl_take),
        .vaddr_wr  (gen_vaddr_valid),
        .pc        (fault_pc),
        .cause     (gen_cause),
        .vaddr     (fault_vaddr),
        .epc1      (epc1),
        .depc      (depc),
        .exc_cause (exc_cause),
        .exc_vaddr (exc_vaddr)
    );

    exc_entry_dbg_regs #(
        .XLEN     (XLEN),
        .DCAUSE_W (DCAUSE_W)
    ) u_dbg (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbg_take    (dbg_take),
        .pc          (fault_pc),
        .cause       (dbg_cause),
        .ps_in       (ps_in),
        .dbg_cause_q (dbg_cause_q),
        .epc_dbg     (epc_dbg),
        .eps_dbg     (eps_dbg)
    );

    // Handler status word
    always_comb begin
        ps_nxt = ps_in;
        ps_nxt[PS_EXCM_BIT] = 1'b1;
        if (dbg_take) ps_nxt[PS_IL_LSB +: PS_IL_W] = DBG_IL;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ps_out  <= '0;
        end else begin
            state_q <= nxt_state;
            if (gen_take || dbg_take) ps_out <= ps_nxt;
        end
    end

    // Output decode
    always_comb begin
        vec_valid = 1'b1;
        vec_sel   = VEC_KERNEL;
        unique case (state_q)
            ST_IDLE:   vec_valid = 1'b0;
            ST_KERNEL: vec_sel   = VEC_KERNEL;
            ST_USER:   vec_sel   = VEC_USER;
            ST_DOUBLE: vec_sel   = VEC_DOUBLE;
            ST_DEBUG:  vec_sel   = VEC_DEBUG;
            default:   vec_valid = 1'b0;
        endcase
    end

    assert_cause_excm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req && !dbg_take) |=> (exc_cause == $past(gen_cause) && ps_out[PS_EXCM_BIT]));

    assert_double_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req && !dbg_take && ps_in[PS_EXCM_BIT]) |=> (vec_valid && vec_sel == VEC_DOUBLE));

    assert_dbg_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_take |=> (ps_out[PS_IL_LSB +: PS_IL_W] == DBG_IL && vec_sel == VEC_DEBUG));

    assert_dbg_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_take && gen_req) |=> ($stable(exc_cause) && $stable(epc1)));

    assert_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_req && !dbg_take) |=> !vec_valid);
endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    localparam int XLEN = 32;
    localparam int CW   = 6;
    localparam int DCW  = 6;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            gen_req;
    logic [CW-1:0]   gen_cause;
    logic            gen_vaddr_valid;
    logic [XLEN-1:0] fault_vaddr;
    logic            dbg_req;
    logic [DCW-1:0]  dbg_cause;
    logic [XLEN-1:0] fault_pc;
    logic [XLEN-1:0] ps_in;

    logic [XLEN-1:0] epc1, depc, exc_vaddr, epc_dbg, eps_dbg, ps_out;
    logic [CW-1:0]   exc_cause;
    logic [DCW-1:0]  dbg_cause_q;
    logic            vec_valid;
    logic [1:0]      vec_sel;

    logic [XLEN-1:0] n_epc1, n_depc, n_exc_vaddr, n_epc_dbg, n_eps_dbg, n_ps_out;
    logic [CW-1:0]   n_exc_cause;
    logic [DCW-1:0]  n_dbg_cause_q;
    logic            n_vec_valid;
    logic [1:0]      n_vec_sel;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .gen_cause(gen_cause),
        .gen_vaddr_valid(gen_vaddr_valid), .fault_vaddr(fault_vaddr),
        .dbg_req(dbg_req), .dbg_cause(dbg_cause), .fault_pc(fault_pc), .ps_in(ps_in),
        .epc1(epc1), .depc(depc), .exc_cause(exc_cause), .exc_vaddr(exc_vaddr),
        .dbg_cause_q(dbg_cause_q), .epc_dbg(epc_dbg), .eps_dbg(eps_dbg),
        .ps_out(ps_out), .vec_valid(vec_valid), .vec_sel(vec_sel)
    );

    exc_entry_ctrl #(.HAS_DEPC(1'b0)) u_exc_entry_ctrl_nodepc (
        .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .gen_cause(gen_cause),
        .gen_vaddr_valid(gen_vaddr_valid), .fault_vaddr(fault_vaddr),
        .dbg_req(dbg_req), .dbg_cause(dbg_cause), .fault_pc(fault_pc), .ps_in(ps_in),
        .epc1(n_epc1), .depc(n_depc), .exc_cause(n_exc_cause), .exc_vaddr(n_exc_vaddr),
        .dbg_cause_q(n_dbg_cause_q), .epc_dbg(n_epc_dbg), .eps_dbg(n_eps_dbg),
        .ps_out(n_ps_out), .vec_valid(n_vec_valid), .vec_sel(n_vec_sel)
    );

    task automatic chk(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        gen_req = 1'b0; gen_cause = '0; gen_vaddr_valid = 1'b0; fault_vaddr = '0;
        dbg_req = 1'b0; dbg_cause = '0; fault_pc = '0;
    endtask

    // Drive one request cycle; return at the following negedge
    task automatic pulse(input logic g, input logic [CW-1:0] gc, input logic vv,
                         input logic [XLEN-1:0] va, input logic d, input logic [DCW-1:0] dc,
                         input logic [XLEN-1:0] pc, input logic [XLEN-1:0] ps);
        @(negedge clk);
        gen_req = g; gen_cause = gc; gen_vaddr_valid = vv; fault_vaddr = va;
        dbg_req = d; dbg_cause = dc; fault_pc = pc; ps_in = ps;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        chk("R1", "epc1", epc1, 0);
        chk("R1", "depc", depc, 0);
        chk("R1", "exc_cause", XLEN'(exc_cause), 0);
        chk("R1", "exc_vaddr", exc_vaddr, 0);
        chk("R1", "dbg_cause", XLEN'(dbg_cause_q), 0);
        chk("R1", "eps_dbg", eps_dbg, 0);
        chk("R1", "ps_out", ps_out, 0);
        chk("R1", "vec_valid", XLEN'(vec_valid), 0);
    endtask

    task automatic t_kernel();
        pulse(1, 6'd5, 0, 32'h1111_0000, 0, 0, 32'h0000_1000, 32'h0000_0000);
        chk("R2", "epc1", epc1, 32'h1000);
        chk("R2", "vec_sel kernel", XLEN'(vec_sel), 0);
        chk("R9", "vec_valid", XLEN'(vec_valid), 1);
        chk("R3", "exc_cause", XLEN'(exc_cause), 5);
        chk("R3", "ps_out", ps_out, 32'h10);
        chk("R5", "exc_vaddr unchanged", exc_vaddr, 0);
        @(negedge clk);
        chk("R9", "vec_valid drops", XLEN'(vec_valid), 0);
    endtask

    task automatic t_user();
        pulse(1, 6'd9, 1, 32'hDEAD_0000, 0, 0, 32'h0000_2000, 32'h0000_0022);
        chk("R2", "epc1", epc1, 32'h2000);
        chk("R2", "vec_sel user", XLEN'(vec_sel), 1);
        chk("R5", "exc_vaddr", exc_vaddr, 32'hDEAD_0000);
        chk("R3", "ps_out", ps_out, 32'h32);
    endtask

    task automatic t_double();
        pulse(1, 6'd3, 0, 0, 0, 0, 32'h0000_3000, 32'h0000_0030);
        chk("R4", "depc", depc, 32'h3000);
        chk("R4", "epc1 kept", epc1, 32'h2000);
        chk("R4", "vec_sel double", XLEN'(vec_sel), 2);
        chk("R3", "ps_out", ps_out, 32'h30);
        chk("R4", "no-depc epc1", n_epc1, 32'h3000);
        chk("R4", "no-depc depc", n_depc, 0);
        chk("R4", "no-depc vec_sel", XLEN'(n_vec_sel), 2);
    endtask

    task automatic t_debug_ok();
        pulse(0, 0, 0, 0, 1, 6'h11, 32'h0000_4000, 32'h0000_0123);
        chk("R7", "dbg_cause", XLEN'(dbg_cause_q), 32'h11);
        chk("R7", "epc_dbg", epc_dbg, 32'h4000);
        chk("R7", "eps_dbg", eps_dbg, 32'h123);
        chk("R7", "ps_out", ps_out, 32'h136);
        chk("R7", "vec_sel debug", XLEN'(vec_sel), 3);
        chk("R7", "exc_cause kept", XLEN'(exc_cause), 3);
    endtask

    task automatic t_debug_reject();
        pulse(0, 0, 0, 0, 1, 6'h2A, 32'h0000_7000, 32'h0000_0006);
        chk("R6", "vec_valid at level", XLEN'(vec_valid), 0);
        chk("R6", "dbg_cause kept", XLEN'(dbg_cause_q), 32'h11);
        chk("R6", "epc_dbg kept", epc_dbg, 32'h4000);
        chk("R6", "ps_out kept", ps_out, 32'h136);
        pulse(0, 0, 0, 0, 1, 6'h2B, 32'h0000_7100, 32'h0000_000F);
        chk("R6", "vec_valid level 15", XLEN'(vec_valid), 0);
        chk("R6", "eps_dbg kept", eps_dbg, 32'h123);
    endtask

    task automatic t_collide();
        pulse(1, 6'd7, 1, 32'h0000_BEEF, 1, 6'h22, 32'h0000_5000, 32'h0000_0001);
        chk("R8", "vec_sel debug", XLEN'(vec_sel), 3);
        chk("R8", "dbg_cause", XLEN'(dbg_cause_q), 32'h22);
        chk("R8", "exc_cause kept", XLEN'(exc_cause), 3);
        chk("R8", "exc_vaddr kept", exc_vaddr, 32'hDEAD_0000);
        chk("R8", "epc1 kept", epc1, 32'h2000);
        chk("R8", "depc kept", depc, 32'h3000);
        pulse(1, 6'd10, 0, 0, 1, 6'h33, 32'h0000_6000, 32'h0000_0007);
        chk("R8", "rejected dbg: vec kernel", XLEN'(vec_sel), 0);
        chk("R8", "rejected dbg: vec_valid", XLEN'(vec_valid), 1);
        chk("R8", "rejected dbg: epc1", epc1, 32'h6000);
        chk("R8", "rejected dbg: exc_cause", XLEN'(exc_cause), 10);
        chk("R8", "rejected dbg: dbg_cause kept", XLEN'(dbg_cause_q), 32'h22);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        gen_req = 1; gen_cause = 6'd1; fault_pc = 32'h8000; ps_in = 32'h20;
        @(negedge clk);
        chk("R9", "first pulse valid", XLEN'(vec_valid), 1);
        chk("R9", "first pulse user", XLEN'(vec_sel), 1);
        gen_cause = 6'd2; fault_pc = 32'h8100; ps_in = 32'h10;
        @(negedge clk);
        idle_inputs();
        chk("R9", "second pulse valid", XLEN'(vec_valid), 1);
        chk("R9", "second pulse double", XLEN'(vec_sel), 2);
        chk("R4", "second depc", depc, 32'h8100);
        @(negedge clk);
        chk("R9", "idle after pair", XLEN'(vec_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        ps_in = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_kernel();
        t_user();
        t_double();
        t_debug_ok();
        t_debug_reject();
        t_collide();
        t_back_to_back();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule